// File: doc/BRIEF.md
# Bit-Addressed Input Probe Port

This block is a read-only peripheral for an 8-bit microprocessor bus with a 16-bit address. It claims a 4K window of the address map and splits that window into eight read strobes, each covering a 512-byte slot. Other input devices on the board use these strobes as their read gating. The strobe for the lowest slot drives a bit-addressed input port. Each of the eight external input lines in that port has an address of its own.

Reading the address of a line returns that line's level on the top data bit. All other data bits read as zero. Software can therefore test one switch or status line with a sign-flag branch, and no mask is needed. Three-state data drivers are modelled as a data bus plus an output-enable. The design is purely combinational and follows the bus signals within the same cycle. Gating by the high phase of the bus clock is selected by a parameter, and it is on by default.

Top module: `bit_probe_port`

## Requirements
- R1: `rd_strobe` is all zero whenever address bits 15:12 differ from 4'h2.
- R2: When `rw` is 0 (a write cycle), `rd_strobe` is all zero and `data_oe` is 0.
- R3: With phi2 gating enabled (the default), `rd_strobe` is all zero and `data_oe` is 0 while `phi2` is 0.
- R4: During a gated read with address bits 15:12 equal to 4'h2, exactly one strobe is high: bit number `addr[11:9]` of `rd_strobe`.
- R5: `data_oe` is 1 exactly when strobe 0 is high, that is, for a gated read of addresses 0x2000 to 0x21FF.
- R6: While `data_oe` is 1, `data_out[7]` equals `probe_in[addr[2:0]]`.
- R7: `data_out[6:0]` always reads zero, and all of `data_out` is zero while `data_oe` is 0.
- R8: Address bits 8:3 have no effect on any output. A port read returns the same value for every setting of these bits.
- R9: Input lines other than the one selected by `addr[2:0]` have no effect on `data_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Bus address |
| rw | input | 1 | Bus direction, 1 for a read cycle, 0 for a write cycle |
| phi2 | input | 1 | Bus clock phase, high during the data transfer |
| probe_in | input | 8 | External input lines, one per bit address |
| rd_strobe | output | 8 | Decoded read strobes for the eight 512-byte slots |
| data_out | output | 8 | Read data; the selected line appears on bit 7 |
| data_oe | output | 1 | Drive enable for `data_out` |

## Verification
The hardest cases to reach from the ports are those where only one qualifier is missing. Examples are a write to the port's own address while `phi2` is high, and a read of the port while `phi2` is low. In both, the address and input lines would otherwise put a 1 on bit 7. The stimulus sets every input line to 1 for these cases, so any leak through the gating shows up as a set data bit or a raised enable. Aliasing and the isolation of input lines are reached with two patterns. One sweeps address bits 8:3 while a single line toggles. The other walks a single 1 through the unselected lines while the selected line stays at 0.

// File: rtl/bit_probe_pkg.sv
package bit_probe_pkg;

  localparam int unsigned BUS_ADDR_W = 16;
  localparam int unsigned BUS_DATA_W = 8;

  typedef logic [BUS_ADDR_W-1:0] bus_addr_t;
  typedef logic [BUS_DATA_W-1:0] bus_data_t;

  // Mask with bits [lsb +: width] set, used to mark consumed address bits.
  function automatic bus_addr_t field_mask(input int unsigned lsb, input int unsigned width);
    bus_addr_t m;
    m = '0;
    for (int unsigned i = 0; i < BUS_ADDR_W; i++) begin
      if (i >= lsb && i < lsb + width) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/bp_region_dec.sv
module bp_region_dec
  import bit_probe_pkg::*;
#(
  parameter int unsigned REGION_LSB = 12,
  parameter int unsigned REGION_W   = BUS_ADDR_W - REGION_LSB,
  parameter logic [REGION_W-1:0] REGION_TAG = 4'h2,
  parameter bit          GATE_PHI2  = 1'b1
) (
  input  bus_addr_t addr,
  input  logic      rw,
  input  logic      phi2,
  output logic      region_rd
);

  logic tag_hit;
  logic phase_ok;

  assign tag_hit = (addr[REGION_LSB +: REGION_W] == REGION_TAG);

  generate
    if (GATE_PHI2) begin : g_phase_gate
      assign phase_ok = phi2;
    end else begin : g_phase_open
      logic unused_phi2;
      assign unused_phi2 = phi2;
      assign phase_ok    = 1'b1;
    end
  endgenerate

  assign region_rd = tag_hit && rw && phase_ok;

endmodule

// File: rtl/bp_strobe_dec.sv
module bp_strobe_dec #(
  parameter int unsigned SLOT_W = 3,
  localparam int unsigned N_SLOT = 1 << SLOT_W
) (
  input  logic              enable,
  input  logic [SLOT_W-1:0] slot,
  output logic [N_SLOT-1:0] strobe
);

  genvar g;
  generate
    for (g = 0; g < N_SLOT; g++) begin : g_slot
      assign strobe[g] = enable && (slot == SLOT_W'(g));
    end
  endgenerate

endmodule

// File: rtl/bp_bit_sel.sv
module bp_bit_sel #(
  parameter int unsigned BIT_W = 3,
  localparam int unsigned N_BIT = 1 << BIT_W
) (
  input  logic [N_BIT-1:0] lines,
  input  logic [BIT_W-1:0] pick,
  output logic             bit_out
);

  logic [N_BIT-1:0] gated;

  genvar g;
  generate
    for (g = 0; g < N_BIT; g++) begin : g_leg
      assign gated[g] = lines[g] && (pick == BIT_W'(g));
    end
  endgenerate

  assign bit_out = |gated;

endmodule

// File: rtl/bit_probe_port.sv
module bit_probe_port
  import bit_probe_pkg::*;
#(
  parameter int unsigned REGION_LSB = 12,
  parameter logic [3:0]  REGION_TAG = 4'h2,
  parameter int unsigned SLOT_LSB   = 9,
  parameter int unsigned SLOT_W     = 3,
  parameter int unsigned BIT_W      = 3,
  parameter int unsigned PORT_SLOT  = 0,
  parameter int unsigned OUT_BIT    = BUS_DATA_W - 1,
  parameter bit          GATE_PHI2  = 1'b1,
  localparam int unsigned N_SLOT    = 1 << SLOT_W,
  localparam int unsigned N_BIT     = 1 << BIT_W
) (
  input  logic [15:0]       addr,
  input  logic              rw,
  input  logic              phi2,
  input  logic [N_BIT-1:0]  probe_in,
  output logic [N_SLOT-1:0] rd_strobe,
  output logic [7:0]        data_out,
  output logic              data_oe
);

  localparam int unsigned REGION_W = BUS_ADDR_W - REGION_LSB;
  localparam bus_addr_t   USED_MASK = field_mask(REGION_LSB, REGION_W)
                                    | field_mask(SLOT_LSB, SLOT_W)
                                    | field_mask(0, BIT_W);

  logic region_rd;
  logic picked;
  logic unused_addr_bits;

  assign unused_addr_bits = ^(addr & ~USED_MASK);

  bp_region_dec #(
    .REGION_LSB (REGION_LSB),
    .REGION_W   (REGION_W),
    .REGION_TAG (REGION_W'(REGION_TAG)),
    .GATE_PHI2  (GATE_PHI2)
  ) u_region (
    .addr      (addr),
    .rw        (rw),
    .phi2      (phi2),
    .region_rd (region_rd)
  );

  bp_strobe_dec #(
    .SLOT_W (SLOT_W)
  ) u_strobe (
    .enable (region_rd),
    .slot   (addr[SLOT_LSB +: SLOT_W]),
    .strobe (rd_strobe)
  );

  bp_bit_sel #(
    .BIT_W (BIT_W)
  ) u_sel (
    .lines   (probe_in),
    .pick    (addr[BIT_W-1:0]),
    .bit_out (picked)
  );

  assign data_oe = rd_strobe[PORT_SLOT];

  always_comb begin
    data_out          = '0;
    data_out[OUT_BIT] = picked && data_oe;
  end

endmodule

// File: rtl/bit_probe_port_chk.sv
module bit_probe_port_chk #(
  parameter bit GATE_PHI2 = 1'b1
) (
  input logic [15:0] addr,
  input logic        rw,
  input logic        phi2,
  input logic [7:0]  probe_in,
  input logic [7:0]  rd_strobe,
  input logic [7:0]  data_out,
  input logic        data_oe
);

  // Sampled at the end of the phi2-high phase, when the bus is settled.
  p_region_r1: assert property (@(negedge phi2)
    (addr[15:12] != 4'h2) |-> (rd_strobe == 8'h00));

  p_write_quiet_r2: assert property (@(negedge phi2)
    !rw |-> (rd_strobe == 8'h00 && !data_oe));

  p_one_strobe_r4: assert property (@(negedge phi2)
    $onehot0(rd_strobe));

  p_slot_pick_r4: assert property (@(negedge phi2)
    (rw && addr[15:12] == 4'h2) |-> rd_strobe[addr[11:9]]);

  p_port_enable_r5: assert property (@(negedge phi2)
    data_oe == (rw && addr[15:9] == 7'h10));

  p_top_bit_r6: assert property (@(negedge phi2)
    data_oe |-> (data_out[7] == probe_in[addr[2:0]]));

  p_low_zero_r7: assert property (@(negedge phi2)
    (data_out[6:0] == 7'h00) && (data_oe || data_out == 8'h00));

  generate
    if (GATE_PHI2) begin : g_phase_chk
      // Sampled just before phi2 rises: the low phase must be quiet.
      p_phase_quiet_r3: assert property (@(posedge phi2)
        (rd_strobe == 8'h00) && !data_oe);
    end
  endgenerate

endmodule

bind bit_probe_port bit_probe_port_chk #(
  .GATE_PHI2 (GATE_PHI2)
) u_chk (
  .addr      (addr),
  .rw        (rw),
  .phi2      (phi2),
  .probe_in  (probe_in),
  .rd_strobe (rd_strobe),
  .data_out  (data_out),
  .data_oe   (data_oe)
);

// File: tb/bit_probe_port_tb_top.sv
module bit_probe_port_tb_top;

  typedef struct {
    string      tag;
    logic [7:0] strobe;
    logic [7:0] data;
    logic       oe;
  } exp_t;

  logic        clk;
  logic [15:0] addr;
  logic        rw;
  logic        phi2;
  logic [7:0]  probe_in;
  logic [7:0]  rd_strobe;
  logic [7:0]  data_out;
  logic        data_oe;

  exp_t exp_q[$];
  int   total;
  int   bad;
  bit   done;
  bit   reported;

  bit_probe_port dut_i (
    .addr      (addr),
    .rw        (rw),
    .phi2      (phi2),
    .probe_in  (probe_in),
    .rd_strobe (rd_strobe),
    .data_out  (data_out),
    .data_oe   (data_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected outputs derived from R1..R7.
  function automatic exp_t model(input logic [15:0] a, input logic r, input logic p,
                                 input logic [7:0] lines, input string tag);
    exp_t e;
    e.tag    = tag;
    e.strobe = 8'h00;
    if (r && p && a[15:12] == 4'h2) e.strobe = 8'h01 << a[11:9];
    e.oe   = e.strobe[0];
    e.data = e.oe ? {lines[a[2:0]], 7'b0} : 8'h00;
    return e;
  endfunction

  task automatic drive(input logic [15:0] a, input logic r, input logic p,
                       input logic [7:0] lines, input string tag);
    @(negedge clk);
    addr     = a;
    rw       = r;
    phi2     = p;
    probe_in = lines;
    exp_q.push_back(model(a, r, p, lines, tag));
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  // Monitor: compare at the rising edge, half a period after the drive.
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (rd_strobe !== e.strobe || data_out !== e.data || data_oe !== e.oe) begin
        bad++;
        $display("FAIL %s: strobe=%h data=%h oe=%b expected strobe=%h data=%h oe=%b",
                 e.tag, rd_strobe, data_out, data_oe, e.strobe, e.data, e.oe);
      end
    end
  end

  initial begin
    total    = 0;
    bad      = 0;
    done     = 1'b0;
    reported = 1'b0;
    addr     = 16'h0000;
    rw       = 1'b0;
    phi2     = 1'b0;
    probe_in = 8'h00;

    // Idle bus: write direction, phi2 low.
    drive(16'h2000, 1'b0, 1'b0, 8'hFF, "R2 idle");

    // R6: each bit address with two input patterns.
    for (int i = 0; i < 8; i++) begin
      drive(16'h2000 | 16'(i), 1'b1, 1'b1, 8'hA5, "R6 pattern A5");
      drive(16'h2000 | 16'(i), 1'b1, 1'b1, 8'h5A, "R6 pattern 5A");
    end

    // R4/R5: every slot in the window.
    for (int s = 0; s < 8; s++) begin
      drive(16'h2000 | 16'(s << 9) | 16'h0001, 1'b1, 1'b1, 8'hFF, "R4 R5 slot sweep");
    end

    // R1: reads outside the window, lines all high.
    drive(16'h1000, 1'b1, 1'b1, 8'hFF, "R1 below window");
    drive(16'h3000, 1'b1, 1'b1, 8'hFF, "R1 above window");
    drive(16'hA000, 1'b1, 1'b1, 8'hFF, "R1 far window");
    drive(16'h1FFF, 1'b1, 1'b1, 8'hFF, "R1 edge below");

    // R2: writes to the port with phi2 high.
    drive(16'h2003, 1'b0, 1'b1, 8'hFF, "R2 write to port");
    drive(16'h2E00, 1'b0, 1'b1, 8'hFF, "R2 write to slot 7");

    // R3: reads with phi2 low.
    drive(16'h2005, 1'b1, 1'b0, 8'hFF, "R3 phi2 low port");
    drive(16'h2600, 1'b1, 1'b0, 8'hFF, "R3 phi2 low slot 3");

    // R8: sweep A8:A3 while bit 4 is selected, line 4 toggling.
    for (int k = 0; k < 64; k++) begin
      drive(16'h2004 | 16'(k << 3), 1'b1, 1'b1, (k % 2) ? 8'h10 : 8'hEF, "R8 alias sweep");
    end

    // R9: selected line 2 low, a single 1 walks through the other lines.
    for (int j = 0; j < 8; j++) begin
      if (j != 2) drive(16'h2002, 1'b1, 1'b1, 8'h01 << j, "R9 walking one");
    end
    drive(16'h2002, 1'b1, 1'b1, 8'hFB, "R9 others high");

    // R7: low data bits stay zero with all lines high.
    drive(16'h2007, 1'b1, 1'b1, 8'hFF, "R7 low bits zero");
    drive(16'h2000, 1'b0, 1'b0, 8'hFF, "R7 idle zero");

    @(negedge clk);
    phi2 = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule